// File: doc/BRIEF.md
# Trace Trap Request Controller

This block decides, instruction by instruction, whether a processor sequencer must take a trace trap (the single-step trap raised when the trace bit of the processor status word is set). The sequencer feeds it one-cycle strobes: instruction decode, instruction end, the new-PC load of a return-from-interrupt (RTI) or return-from-trap (RTT), and the successful end of a vector flow. It also feeds an abort strobe and two qualifiers that mark the ending instruction as a WAIT or an SPL. Beside the strobes it reads the current trace bit, the current mode, and two flags that report a pending interrupt or a pending higher-ranked trap.

The block holds one request flag. The flag is loaded from the trace bit when an instruction is decoded, and the trap decision is made when that instruction ends. A return or a vector flow loads the flag from the newly installed status word instead of only setting it. This keeps the corner cases exact. A traced RTI that restores an untraced status word does not trap, and an RTT never traps. A vector whose new status word is traced traps before the first handler instruction runs. When the block decides to trap, it raises a one-cycle take strobe together with the fixed trap vector. The sequencer then runs the vector flow.

Top module: `ttrq_ctl`

## Requirements
- R1: After reset the request flag is clear, and `ttrap_take` stays low through an instruction end that has no preceding decode.
- R2: A decode strobe loads the request flag with `psw_t`. An earlier request is overwritten when the trace bit reads 0.
- R3: When `end_stb` is high with the flag set, no abort, no pending interrupt or trap, and no kernel-mode WAIT or SPL, `ttrap_take` is high for exactly the one cycle after that `end_stb` cycle. `ttrap_take` is never high in any other cycle.
- R4: An RTI new-PC load strobe loads the flag with `psw_t`, which at that time is the trace bit of the restored status word.
- R5: An RTT new-PC load strobe clears the flag, so the RTT ends without a trace trap.
- R6: `vec_done_stb` counts as an instruction end evaluated with `psw_t` (the new status word's trace bit). When that bit is 1 and nothing is pending, `ttrap_take` is high in the next cycle.
- R7: When an interrupt or a higher-ranked trap is pending at an instruction end, no trace trap is taken and the request is held. A later end with nothing pending then takes the trap.
- R8: When WAIT or SPL ends in kernel mode (`kern_mode`=1), the request is dropped without a trap. When they end in user mode, they are traced like any other instruction.
- R9: An abort clears the flag and suppresses the trap, also when it falls in the same cycle as `end_stb`.
- R10: `ttrap_vec` carries the trap vector 014 octal (12 decimal) whenever `ttrap_take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_stb | input | 1 | Instruction decode strobe |
| end_stb | input | 1 | Instruction end strobe |
| rti_ld_stb | input | 1 | RTI new-PC load strobe |
| rtt_ld_stb | input | 1 | RTT new-PC load strobe |
| vec_done_stb | input | 1 | Vector flow completed successfully |
| abort_stb | input | 1 | Instruction aborted |
| wait_qual | input | 1 | Ending instruction is a WAIT (with end_stb) |
| spl_qual | input | 1 | Ending instruction is an SPL (with end_stb) |
| psw_t | input | 1 | Current trace bit of the status word |
| kern_mode | input | 1 | Current mode is kernel |
| int_pend | input | 1 | An interrupt is pending |
| trap_pend | input | 1 | A higher-ranked trap is pending |
| ttrap_take | output | 1 | Take the trace trap (one-cycle strobe) |
| ttrap_vec | output | VEC_W | Trace trap vector address |

## Verification
The hardest situation to reach is a request that outlives one instruction end. This happens when a pending interrupt defers a trace trap. The flag must then survive to a later end, and any return or vector flow that follows may overwrite it. The bench reaches this state by raising `int_pend` at the end of a traced instruction. It then fires a second end with nothing pending and no decode between the two ends. It also runs a vector-done strobe while an interrupt is pending, and it sweeps every mix of trace bit, pending flags, mode and WAIT/SPL qualifiers around a decode/end pair.

// File: rtl/ttrq_pkg.sv
package ttrq_pkg;

  typedef enum logic [2:0] {
    DC_IDLE     = 3'd0,
    DC_TAKE     = 3'd1,
    DC_DEFER    = 3'd2,
    DC_SUPPRESS = 3'd3,
    DC_ABORT    = 3'd4
  } ttrq_dec_e;

  // Decision made at an instruction end or at the end of a vector flow.
  function automatic ttrq_dec_e ttrq_decide(
    input logic end_stb, input logic vec_done, input logic abort,
    input logic flag,    input logic psw_t,
    input logic int_pend, input logic trap_pend,
    input logic wait_q,  input logic spl_q, input logic kern);
    logic eff;
    eff = vec_done ? psw_t : flag;
    if (abort)                                return DC_ABORT;
    else if (!(end_stb || vec_done))          return DC_IDLE;
    else if (!eff)                            return DC_IDLE;
    else if (end_stb && kern && (wait_q || spl_q)) return DC_SUPPRESS;
    else if (int_pend || trap_pend)           return DC_DEFER;
    else                                      return DC_TAKE;
  endfunction

  // Next value of the request flag.
  function automatic logic ttrq_next_flag(
    input logic flag, input logic psw_t,
    input logic abort, input logic rtt, input logic rti,
    input logic dec, input logic vec_done, input ttrq_dec_e dc);
    if (abort)                                   return 1'b0;
    else if (rtt)                                return 1'b0;
    else if (rti)                                return psw_t;
    else if (dec)                                return psw_t;
    else if (dc == DC_TAKE || dc == DC_SUPPRESS) return 1'b0;
    else if (vec_done)                           return psw_t;
    else                                         return flag;
  endfunction

endpackage

// File: rtl/ttrq_arb.sv
module ttrq_arb
  import ttrq_pkg::*;
(
  input  logic      end_stb,
  input  logic      vec_done_stb,
  input  logic      abort_stb,
  input  logic      flag_q,
  input  logic      psw_t,
  input  logic      int_pend,
  input  logic      trap_pend,
  input  logic      wait_qual,
  input  logic      spl_qual,
  input  logic      kern_mode,
  output ttrq_dec_e decision,
  output logic      take_now
);

  always_comb begin
    decision = ttrq_decide(end_stb, vec_done_stb, abort_stb, flag_q, psw_t,
                           int_pend, trap_pend, wait_qual, spl_qual, kern_mode);
    take_now = (decision == DC_TAKE);
  end

endmodule

// File: rtl/ttrq_flag.sv
module ttrq_flag
  import ttrq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dec_stb,
  input  logic      rti_ld_stb,
  input  logic      rtt_ld_stb,
  input  logic      vec_done_stb,
  input  logic      abort_stb,
  input  logic      psw_t,
  input  ttrq_dec_e decision,
  output logic      flag_q
);

  logic flag_d;

  always_comb
    flag_d = ttrq_next_flag(flag_q, psw_t, abort_stb, rtt_ld_stb, rti_ld_stb,
                            dec_stb, vec_done_stb, decision);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R9
  abort_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !flag_q);

  // R5
  rtt_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtt_ld_stb && !abort_stb) |=> !flag_q);

  // R2
  dec_loads_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && !abort_stb && !rtt_ld_stb && !rti_ld_stb) |=> (flag_q == $past(psw_t)));

endmodule

// File: rtl/ttrq_take.sv
module ttrq_take #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_now,
  output logic take_o
);

  generate
    if (REG_OUT) begin : g_reg
      logic take_q;
      always_ff @(posedge clk) begin
        if (!rst_n) take_q <= 1'b0;
        else        take_q <= take_now;
      end
      assign take_o = take_q;
    end else begin : g_comb
      assign take_o = take_now;
    end
  endgenerate

endmodule

// File: rtl/ttrq_ctl.sv
module ttrq_ctl #(
  parameter int             VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_ADDR = 9'o014,
  parameter bit             REG_OUT  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_stb,
  input  logic             end_stb,
  input  logic             rti_ld_stb,
  input  logic             rtt_ld_stb,
  input  logic             vec_done_stb,
  input  logic             abort_stb,
  input  logic             wait_qual,
  input  logic             spl_qual,
  input  logic             psw_t,
  input  logic             kern_mode,
  input  logic             int_pend,
  input  logic             trap_pend,
  output logic             ttrap_take,
  output logic [VEC_W-1:0] ttrap_vec
);
  import ttrq_pkg::*;

  ttrq_dec_e decision;
  logic      take_now;
  logic      flag_q;

  ttrq_arb u_arb (
    .end_stb      (end_stb),
    .vec_done_stb (vec_done_stb),
    .abort_stb    (abort_stb),
    .flag_q       (flag_q),
    .psw_t        (psw_t),
    .int_pend     (int_pend),
    .trap_pend    (trap_pend),
    .wait_qual    (wait_qual),
    .spl_qual     (spl_qual),
    .kern_mode    (kern_mode),
    .decision     (decision),
    .take_now     (take_now)
  );

  ttrq_flag u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_stb      (dec_stb),
    .rti_ld_stb   (rti_ld_stb),
    .rtt_ld_stb   (rtt_ld_stb),
    .vec_done_stb (vec_done_stb),
    .abort_stb    (abort_stb),
    .psw_t        (psw_t),
    .decision     (decision),
    .flag_q       (flag_q)
  );

  ttrq_take #(.REG_OUT(REG_OUT)) u_take (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_now (take_now),
    .take_o   (ttrap_take)
  );

  assign ttrap_vec = VEC_ADDR;

  generate
    if (REG_OUT) begin : g_chk
      // R3
      take_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ttrap_take |-> $past(end_stb || vec_done_stb));

      // R7
      pending_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((end_stb || vec_done_stb) && (int_pend || trap_pend)) |=> !ttrap_take);

      // R9
      abort_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_stb |=> !ttrap_take);

      // R8
      kernel_wait_spl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_stb && !vec_done_stb && kern_mode && (wait_qual || spl_qual)) |=> !ttrap_take);
    end
  endgenerate

endmodule

// File: tb/ttrq_ctl_bench.sv
`timescale 1ns/1ps
module ttrq_ctl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_stb = 0, end_stb = 0, rti_ld_stb = 0, rtt_ld_stb = 0;
  logic vec_done_stb = 0, abort_stb = 0, wait_qual = 0, spl_qual = 0;
  logic psw_t = 0, kern_mode = 0, int_pend = 0, trap_pend = 0;
  logic       ttrap_take;
  logic [8:0] ttrap_vec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ttrq_ctl u_ttrq_ctl (
    .clk(clk), .rst_n(rst_n),
    .dec_stb(dec_stb), .end_stb(end_stb),
    .rti_ld_stb(rti_ld_stb), .rtt_ld_stb(rtt_ld_stb),
    .vec_done_stb(vec_done_stb), .abort_stb(abort_stb),
    .wait_qual(wait_qual), .spl_qual(spl_qual),
    .psw_t(psw_t), .kern_mode(kern_mode),
    .int_pend(int_pend), .trap_pend(trap_pend),
    .ttrap_take(ttrap_take), .ttrap_vec(ttrap_vec)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: take=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic check_vec(input string req);
    checks++;
    if (ttrap_vec !== 9'd12) begin
      errors++;
      $display("FAIL %s: vec=%0o expected 14", req, ttrap_vec);
    end
  endtask

  // One clock with the current inputs, then strobes return low.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    dec_stb = 0; end_stb = 0; rti_ld_stb = 0; rtt_ld_stb = 0;
    vec_done_stb = 0; abort_stb = 0; wait_qual = 0; spl_qual = 0;
  endtask

  task automatic clear_ctx();
    int_pend = 0; trap_pend = 0; kern_mode = 0; psw_t = 0;
  endtask

  task automatic decode(input logic t);
    psw_t = t; dec_stb = 1; tick();
  endtask

  task automatic finish_instr(input logic ip, input logic tp,
                              input logic w, input logic s, input logic k);
    int_pend = ip; trap_pend = tp; wait_qual = w; spl_qual = s; kern_mode = k;
    end_stb = 1; tick();
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, take=%0b expected completion", ttrap_take);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(ttrap_take, 1'b0, "R1 reset");
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R1 end after reset");
    check_vec("R10 vector");

    // Sweep: decode trace bit x pending flags x WAIT/SPL x mode
    for (int c = 0; c < 64; c++) begin
      logic t, ip, tp, w, s, k, exp;
      string req;
      {t, ip, tp, w, s, k} = c[5:0];
      clear_ctx();
      decode(t);
      finish_instr(ip, tp, w, s, k);
      exp = t && !(k && (w || s)) && !ip && !tp;
      if (!t) req = "R2 untraced";
      else if (k && (w || s)) req = "R8 kernel wait/spl";
      else if (ip || tp) req = "R7 pending";
      else if (w || s) req = "R8 user wait/spl";
      else req = "R3 traced";
      check(ttrap_take, exp, req);
      if (exp) check_vec("R10 vector on take");
      clear_ctx();
      finish_instr(0, 0, 0, 0, 0);   // second end: deferred request is taken
      check(ttrap_take, t && !(k && (w || s)) && (ip || tp), "R7 held then taken / R3 single cycle");
      tick();
      check(ttrap_take, 1'b0, "R3 one cycle");
    end

    // R2: later decode with trace 0 overwrites a set request
    clear_ctx(); decode(1); decode(0); finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R2 overwrite");

    // R4: traced RTI restoring untraced PS does not trap
    clear_ctx(); decode(1); psw_t = 0; rti_ld_stb = 1; tick();
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R4 rti to t=0");
    // R4: untraced RTI restoring traced PS traps
    clear_ctx(); decode(0); psw_t = 1; rti_ld_stb = 1; tick();
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b1, "R4 rti to t=1");

    // R5: RTT never traps
    clear_ctx(); decode(1); psw_t = 1; rtt_ld_stb = 1; tick();
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R5 rtt");

    // R6: vector loading traced PS traps at once
    clear_ctx(); psw_t = 1; vec_done_stb = 1; tick();
    check(ttrap_take, 1'b1, "R6 vector t=1");
    check_vec("R10 vector after vector flow");
    clear_ctx(); decode(1); psw_t = 0; vec_done_stb = 1; tick();
    check(ttrap_take, 1'b0, "R6 vector t=0");
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R6 vector t=0 clears request");
    // R6 + R7: vector with interrupt pending defers, later end takes
    clear_ctx(); psw_t = 1; int_pend = 1; vec_done_stb = 1; tick();
    check(ttrap_take, 1'b0, "R7 vector deferred");
    clear_ctx(); finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b1, "R7 vector deferred then taken");

    // R9: abort coinciding with end
    clear_ctx(); decode(1); abort_stb = 1; finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R9 abort with end");
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R9 flag cleared");
    // R9: abort alone before end
    clear_ctx(); decode(1); abort_stb = 1; tick();
    finish_instr(0, 0, 0, 0, 0);
    check(ttrap_take, 1'b0, "R9 abort before end");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule